// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Engine

This block takes received Ethernet frames as a byte stream and stores each one in a memory buffer. Software describes the buffers with a chain of descriptors in memory. Each descriptor is 32 bytes long, aligned to 32 bytes, and holds eight little-endian 32-bit words. The engine reads a descriptor over a simple 32-bit memory master port and checks that it owns it. It then stores the frame, writing the bytes little-endian with byte enables on a partial last word. Finally it writes back the byte count and a status half-word, and clears the ownership bit so software can take the buffer.

Software starts the queue through a small register port. It sets the run and queue-enable bits, writes the descriptor address to the pointer-low register, and then writes the pointer-high register with its valid bit set. A flag in the next-pointer high word marks the last descriptor of a chain. When that descriptor is done, the engine raises an end-of-queue flag, which is cleared by writing 1, and stops.

A frame can arrive when the engine holds no owned descriptor. In that case the engine still accepts the bytes, discards them and counts the frame as dropped. MAC framing and CRC checking are done upstream: the frame-check result arrives on an input.

Top module: `rx_desc_dma`

## Requirements
- R1: Register word index 0 is control, with bit 15 as run and bit 0 as queue enable. Index 1 is the descriptor pointer, index 2 holds the valid flag in bit 31, and index 3 is the end-of-queue status in bit 0. No memory request is made unless run, enable and valid are all 1.
- R2: A fetch reads descriptor words 0 to 5 at pointer + 4·k. Word 0 is the buffer byte address. Word 2 is the next-descriptor address. Bit 31 of word 3 marks the last descriptor. The upper half of word 4 is a tag that is kept. Bits 31:16 of word 5 give the buffer capacity in bytes.
- R3: If bit 15 (owner) of fetched word 5 is 0, the engine writes nothing to memory, clears the valid flag (which then reads back as 0) and stops.
- R4: Frame byte i is written to buffer byte address buf + i, packed little-endian in 32-bit words. A partial final word sets only the byte enables of the bytes it holds, so the following buffer bytes are left untouched.
- R5: Write-back sets word 4 to {kept tag, stored byte count}. Word 5 becomes {capacity, status}, where status has owner bit 15 = 0, end-of-frame bit 0 = 1 and start-of-frame bit 1 = 1.
- R6: When a frame is longer than the capacity, only capacity bytes are stored, the count equals the capacity, and status bits 11 (too long) and 8 (bad frame) are set.
- R7: When a frame is shorter than MIN_LEN bytes, status bits 4 (short) and 8 are set.
- R8: A CRC-error input seen during the frame sets status bits 12 and 8. An overrun input sets bits 9 and 8. The descriptor is handed back to software in both cases.
- R9: A descriptor not marked last makes the engine load its next address into the pointer register and fetch from there. After the last one it sets end-of-queue, clears valid and stops.
- R10: Writing 1 to end-of-queue bit 0 clears it. Writing 0 leaves it set.
- R11: A frame that arrives while no owned descriptor is held is accepted and thrown away. drop_count increases by 1 per such frame, and no memory write occurs.
- R12: rx_ready is 1 only while a descriptor is receiving with no write outstanding, or while a frame is being dropped. It is 0 during fetch and write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register word index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the frame's last |
| rx_crc_err | input | 1 | Frame check failed |
| rx_ovr_err | input | 1 | Upstream overrun |
| rx_ready | output | 1 | Byte accepted this cycle when valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| drop_count | output | DROP_W | Frames dropped for lack of a descriptor |

## Verification
The bench builds the engine with MIN_LEN = 12 and DROP_W = 8. With these values, frames of a few dozen bytes are enough to cover both sides of the short-frame boundary and the capacity limit, and the buffers fit in a 1 KB memory model. With 8-bit drop counting, the counter can be checked directly. Capacities such as 3 and 14 lead to partial final words, which tests the byte-enable rules.

// File: rtl/rxd_pkg.sv
// Shared constants and types for the receive descriptor DMA engine.
// Assumes 32-bit memory words and byte-oriented frame input.
package rxd_pkg;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = 16;
    localparam int CSR_AW    = 2;
    localparam int FETCH_CNT = 6;          // descriptor words read per fetch

    // register word indices
    localparam logic [CSR_AW-1:0] CSR_CTRL = 2'd0;
    localparam logic [CSR_AW-1:0] CSR_PLO  = 2'd1;
    localparam logic [CSR_AW-1:0] CSR_PHI  = 2'd2;
    localparam logic [CSR_AW-1:0] CSR_XST  = 2'd3;

    localparam int CTL_RUN   = 15;
    localparam int CTL_QEN   = 0;
    localparam int PTR_VLD   = 31;
    localparam int NXT_LAST  = 31;

    // status half-word bit positions
    localparam int SB_EOF    = 0;
    localparam int SB_SOF    = 1;
    localparam int SB_SHORT  = 4;
    localparam int SB_BAD    = 8;
    localparam int SB_OVR    = 9;
    localparam int SB_TOOBIG = 11;
    localparam int SB_CRC    = 12;
    localparam int SB_OWN    = 15;

    // descriptor word indices used at write-back
    localparam int DW_LEN    = 4;
    localparam int DW_STAT   = 5;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_RECV  = 3'd2,
        ST_WBACK = 3'd3,
        ST_DROP  = 3'd4
    } rxd_state_e;
endpackage

// File: rtl/rxd_csr.sv
// Host register file: control, descriptor pointer with valid flag and the
// write-1-to-clear end-of-queue flag. Engine updates win over host writes
// made in the same cycle.
module rxd_csr
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_AW-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              ptr_adv,
    input  logic [WORD_W-1:0] ptr_next,
    input  logic              valid_drop,
    input  logic              eoq_set,
    output logic              run,
    output logic [WORD_W-1:0] desc_ptr,
    output logic              ptr_valid,
    output logic              eoq
);
    logic ctl_run_q, ctl_qen_q;

    // register updates from host writes and engine events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_run_q <= 1'b0;
            ctl_qen_q <= 1'b0;
            desc_ptr  <= '0;
            ptr_valid <= 1'b0;
            eoq       <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    CSR_CTRL: begin
                        ctl_run_q <= wr_data[CTL_RUN];
                        ctl_qen_q <= wr_data[CTL_QEN];
                    end
                    CSR_PLO: desc_ptr  <= wr_data;
                    CSR_PHI: ptr_valid <= wr_data[PTR_VLD];
                    default: if (wr_data[0]) eoq <= 1'b0;
                endcase
            end
            if (ptr_adv)    desc_ptr  <= ptr_next;
            if (valid_drop) ptr_valid <= 1'b0;
            if (eoq_set)    eoq       <= 1'b1;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        case (addr)
            CSR_CTRL: begin
                rd_data[CTL_RUN] = ctl_run_q;
                rd_data[CTL_QEN] = ctl_qen_q;
            end
            CSR_PLO: rd_data = desc_ptr;
            CSR_PHI: rd_data[PTR_VLD] = ptr_valid;
            default: rd_data[0] = eoq;
        endcase
    end

    assign run = ctl_run_q & ctl_qen_q & ptr_valid;
endmodule

// File: rtl/rxd_packer.sv
// Packs frame bytes little-endian into memory words. Emits a word when the
// top lane fills or at frame end with any held byte; byte enables mark
// which lanes carry data. Assumes the consumer takes each emitted word.
module rxd_packer #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          fin,
    output logic [DW-1:0] word,
    output logic [DW/8-1:0] be,
    output logic          emit
);
    localparam int LANES = DW / 8;
    localparam int LW    = $clog2(LANES);

    logic [LW-1:0]    lane_q;
    logic [DW-1:0]    hold_q;
    logic [LANES-1:0] hold_be_q;

    // merge the incoming byte into the held partial word
    always_comb begin
        word = hold_q;
        be   = hold_be_q;
        if (push) begin
            word[{lane_q, 3'b000} +: 8] = din;
            be[lane_q]                  = 1'b1;
        end
        emit = (push && lane_q == LW'(LANES - 1)) || (fin && (push || lane_q != '0));
    end

    // lane pointer and partial-word storage
    always_ff @(posedge clk) begin
        if (!rst_n || clr || emit) begin
            lane_q    <= '0;
            hold_q    <= '0;
            hold_be_q <= '0;
        end else if (push) begin
            lane_q    <= lane_q + 1'b1;
            hold_q    <= word;
            hold_be_q <= be;
        end
    end
endmodule

// File: rtl/rxd_status.sv
// Encodes the written-back status half-word from the frame's outcome.
// Ownership is always returned; any error also marks the frame bad.
module rxd_status
    import rxd_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 16
) (
    input  logic [LEN_W-1:0]  total,
    input  logic              over_cap,
    input  logic              crc_err,
    input  logic              ovr_err,
    output logic [HALF_W-1:0] status
);
    logic short_f;

    // status bit assembly
    always_comb begin
        short_f           = total < LEN_W'(MIN_LEN);
        status            = '0;
        status[SB_EOF]    = 1'b1;
        status[SB_SOF]    = 1'b1;
        status[SB_SHORT]  = short_f;
        status[SB_TOOBIG] = over_cap;
        status[SB_CRC]    = crc_err;
        status[SB_OVR]    = ovr_err;
        status[SB_BAD]    = short_f | over_cap | crc_err | ovr_err;
        status[SB_OWN]    = 1'b0;
    end
endmodule

// File: rtl/rx_desc_dma.sv
// Receive DMA engine walking a linked list of 32-byte descriptors.
// Fetches a descriptor, stores one frame into its buffer, writes back
// length and status, then follows the chain or stops at the last one.
// Assumes one outstanding memory access and word-aligned buffer addresses.
module rx_desc_dma
    import rxd_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int DROP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [1:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_crc_err,
    input  logic              rx_ovr_err,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [DROP_W-1:0] drop_count
);
    localparam int LEN_W  = HALF_W;
    localparam int LANES  = WORD_W / 8;
    localparam int WIDX_W = LEN_W - $clog2(LANES);
    localparam int FIDX_W = $clog2(FETCH_CNT);

    rxd_state_e        st_q;
    logic [FIDX_W-1:0] fidx_q;
    logic              wb_sel_q;
    logic [WORD_W-1:0] buf_q, nxt_q;
    logic              nxt_last_q;
    logic [LEN_W-1:0]  tag_q, cap_q, stored_q, total_q;
    logic              over_q, crc_q, ovr_q, fin_q, wr_pend_q;
    logic [WORD_W-1:0] wr_data_q;
    logic [LANES-1:0]  wr_be_q;
    logic [WIDX_W-1:0] widx_q;
    logic [DROP_W-1:0] drop_q;

    logic              run_w, ptr_valid_w, eoq_w;
    logic [WORD_W-1:0] desc_ptr_w;
    logic              accept, store, fin;
    logic [WORD_W-1:0] pk_word;
    logic [LANES-1:0]  pk_be;
    logic              pk_emit;
    logic [HALF_W-1:0] stat_w;
    logic              fetch_done, wb_done, owned;

    // handshake and event decode
    always_comb begin
        rx_ready   = (st_q == ST_RECV && !wr_pend_q && !fin_q) || st_q == ST_DROP;
        accept     = st_q == ST_RECV && rx_valid && rx_ready;
        store      = accept && (stored_q < cap_q);
        fin        = accept && rx_last;
        owned      = mem_rdata[SB_OWN];
        fetch_done = st_q == ST_FETCH && mem_ack && fidx_q == FIDX_W'(FETCH_CNT - 1);
        wb_done    = st_q == ST_WBACK && mem_ack && wb_sel_q;
    end

    rxd_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (csr_wr),
        .addr       (csr_addr),
        .wr_data    (csr_wdata),
        .rd_data    (csr_rdata),
        .ptr_adv    (wb_done && !nxt_last_q),
        .ptr_next   (nxt_q),
        .valid_drop ((fetch_done && !owned) || (wb_done && nxt_last_q)),
        .eoq_set    (wb_done && nxt_last_q),
        .run        (run_w),
        .desc_ptr   (desc_ptr_w),
        .ptr_valid  (ptr_valid_w),
        .eoq        (eoq_w)
    );

    rxd_packer #(.DW(WORD_W)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_q != ST_RECV),
        .push  (store),
        .din   (rx_data),
        .fin   (fin),
        .word  (pk_word),
        .be    (pk_be),
        .emit  (pk_emit)
    );

    rxd_status #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_stat (
        .total    (total_q),
        .over_cap (over_q),
        .crc_err  (crc_q),
        .ovr_err  (ovr_q),
        .status   (stat_w)
    );

    // memory port drive per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        case (st_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr_w + (WORD_W'(fidx_q) << 2);
            end
            ST_RECV: begin
                mem_req   = wr_pend_q;
                mem_we    = wr_pend_q;
                mem_addr  = buf_q + WORD_W'({widx_q, 2'b00});
                mem_wdata = wr_data_q;
                mem_be    = wr_be_q;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = '1;
                mem_addr  = desc_ptr_w + WORD_W'((wb_sel_q ? DW_STAT : DW_LEN) * 4);
                mem_wdata = wb_sel_q ? {cap_q, stat_w} : {tag_q, stored_q};
            end
            default: ;
        endcase
    end

    // engine sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            fidx_q     <= '0;
            wb_sel_q   <= 1'b0;
            buf_q      <= '0;
            nxt_q      <= '0;
            nxt_last_q <= 1'b0;
            tag_q      <= '0;
            cap_q      <= '0;
            stored_q   <= '0;
            total_q    <= '0;
            over_q     <= 1'b0;
            crc_q      <= 1'b0;
            ovr_q      <= 1'b0;
            fin_q      <= 1'b0;
            wr_pend_q  <= 1'b0;
            wr_data_q  <= '0;
            wr_be_q    <= '0;
            widx_q     <= '0;
            drop_q     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (run_w) begin
                        st_q   <= ST_FETCH;
                        fidx_q <= '0;
                    end else if (rx_valid) begin
                        st_q <= ST_DROP;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        case (int'(fidx_q))
                            0:       buf_q      <= mem_rdata;
                            2:       nxt_q      <= mem_rdata;
                            3:       nxt_last_q <= mem_rdata[NXT_LAST];
                            4:       tag_q      <= mem_rdata[WORD_W-1:HALF_W];
                            5:       cap_q      <= mem_rdata[WORD_W-1:HALF_W];
                            default: ;
                        endcase
                        if (fetch_done) begin
                            st_q      <= owned ? ST_RECV : ST_IDLE;
                            stored_q  <= '0;
                            total_q   <= '0;
                            over_q    <= 1'b0;
                            crc_q     <= 1'b0;
                            ovr_q     <= 1'b0;
                            fin_q     <= 1'b0;
                            wr_pend_q <= 1'b0;
                            widx_q    <= '0;
                        end else begin
                            fidx_q <= fidx_q + 1'b1;
                        end
                    end
                end
                ST_RECV: begin
                    if (accept) begin
                        if (total_q != '1) total_q <= total_q + 1'b1;
                        if (store) stored_q <= stored_q + 1'b1;
                        else       over_q   <= 1'b1;
                        crc_q <= crc_q | rx_crc_err;
                        ovr_q <= ovr_q | rx_ovr_err;
                        if (rx_last) fin_q <= 1'b1;
                    end
                    if (pk_emit) begin
                        wr_pend_q <= 1'b1;
                        wr_data_q <= pk_word;
                        wr_be_q   <= pk_be;
                    end
                    if (fin && !pk_emit) begin
                        st_q     <= ST_WBACK;
                        wb_sel_q <= 1'b0;
                    end
                    if (wr_pend_q && mem_ack) begin
                        wr_pend_q <= 1'b0;
                        widx_q    <= widx_q + 1'b1;
                        if (fin_q) begin
                            st_q     <= ST_WBACK;
                            wb_sel_q <= 1'b0;
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        if (!wb_sel_q) begin
                            wb_sel_q <= 1'b1;
                        end else if (!nxt_last_q && run_w) begin
                            st_q   <= ST_FETCH;
                            fidx_q <= '0;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                ST_DROP: begin
                    if (rx_valid && rx_last) begin
                        drop_q <= drop_q + 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign drop_count = drop_q;
endmodule

// File: rtl/rxd_checker.sv
// Temporal checks on the receive DMA engine, attached by bind.
module rxd_checker
    import rxd_pkg::*;
#(
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input rxd_state_e        st,
    input logic              wb_sel,
    input logic              rx_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic              eoq,
    input logic              ptr_valid,
    input logic [DROP_W-1:0] drop_count
);
    assert_write_states_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (st == ST_RECV || st == ST_WBACK));

    assert_fetch_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH && mem_req) |-> !mem_we);

    assert_be_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
        (mem_be == 4'b0001 || mem_be == 4'b0011 || mem_be == 4'b0111 || mem_be == 4'b1111));

    assert_owner_returned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && st == ST_WBACK && wb_sel) |->
        (!mem_wdata[SB_OWN] && mem_wdata[SB_EOF] && mem_wdata[SB_SOF]));

    assert_eoq_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoq) |-> (st == ST_IDLE && !ptr_valid));

    assert_drop_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |->
        ($past(st) == ST_DROP && drop_count == DROP_W'($past(drop_count) + 1'b1)));

    assert_ready_states_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (st == ST_RECV || st == ST_DROP));
endmodule

bind rx_desc_dma rxd_checker #(.DROP_W(DROP_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st_q),
    .wb_sel     (wb_sel_q),
    .rx_ready   (rx_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .eoq        (eoq_w),
    .ptr_valid  (ptr_valid_w),
    .drop_count (drop_count)
);

// File: tb/rx_desc_dma_test.sv
module rx_desc_dma_test;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_LEN    = 12;
    localparam int DROP_W     = 8;
    localparam logic [31:0] BUF_A = 32'h200;
    localparam logic [31:0] BUF_B = 32'h300;

    logic clk = 1'b0, rst_n = 1'b0;
    logic csr_wr = 1'b0;
    logic [1:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0, csr_rdata;
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_crc_err = 1'b0, rx_ovr_err = 1'b0, rx_ready;
    logic [7:0] rx_data = '0;
    logic mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0] mem_be;
    logic [DROP_W-1:0] drop_count;

    logic [31:0] mem [0:255];
    int checks = 0, errors = 0, wr_cnt = 0, req_cnt = 0;
    bit done = 0;

    rx_desc_dma #(.MIN_LEN(MIN_LEN), .DROP_W(DROP_W)) uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_crc_err(rx_crc_err),
        .rx_ovr_err(rx_ovr_err), .rx_ready(rx_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .drop_count(drop_count));

    always #(CLK_PERIOD/2) clk = ~clk;

    // zero-wait memory model
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) begin
        if (mem_req) req_cnt++;
        if (mem_req && mem_we) begin
            wr_cnt++;
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
        end
    end

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] cap;
        logic        crc;
        logic        ovr;
        logic [15:0] cnt;
        logic [15:0] stat;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{16'd16, 16'd64, 1'b0, 1'b0, 16'd16, 16'h0003},
        '{16'd13, 16'd64, 1'b0, 1'b0, 16'd13, 16'h0003},
        '{16'd8,  16'd64, 1'b0, 1'b0, 16'd8,  16'h0113},
        '{16'd30, 16'd20, 1'b0, 1'b0, 16'd20, 16'h0903},
        '{16'd20, 16'd64, 1'b1, 1'b0, 16'd20, 16'h1103},
        '{16'd22, 16'd64, 1'b0, 1'b1, 16'd22, 16'h0303},
        '{16'd14, 16'd14, 1'b0, 1'b0, 16'd14, 16'h0003},
        '{16'd5,  16'd3,  1'b1, 1'b0, 16'd3,  16'h1913}
    };

    function automatic logic [7:0] fb(input int seed, input int i);
        return 8'((seed * 31 + i * 7 + 1) & 255);
    endfunction

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        return mem[a[9:2]][a[1:0]*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic set_desc(input logic [31:0] base, input logic [31:0] bufa,
                            input logic [31:0] nxt, input bit last,
                            input logic [15:0] cap, input bit own);
        mem[base[9:2] + 0] = bufa;
        mem[base[9:2] + 1] = 32'h0;
        mem[base[9:2] + 2] = nxt;
        mem[base[9:2] + 3] = {last, 31'h0};
        mem[base[9:2] + 4] = 32'hABCD_0000;
        mem[base[9:2] + 5] = {cap, own, 15'h0};
        mem[base[9:2] + 6] = 32'h0;
        mem[base[9:2] + 7] = 32'h0;
        for (int w = 0; w < 32; w++) mem[bufa[9:2] + w] = 32'hEEEE_EEEE;
    endtask

    task automatic start_q(input logic [31:0] p);
        csr_write(2'd1, p);
        csr_write(2'd2, 32'h8000_0000);
    endtask

    task automatic send_frame(input int len, input int seed, input bit crc, input bit ovr);
        for (int i = 0; i < len; i++) begin
            bit took;
            took = 1'b0;
            rx_valid = 1'b1; rx_data = fb(seed, i); rx_last = (i == len - 1);
            rx_crc_err = crc && (i == len - 1); rx_ovr_err = ovr && (i == len - 1);
            while (!took) begin
                took = rx_ready;
                @(negedge clk);
            end
        end
        rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; rx_ovr_err = 1'b0;
    endtask

    task automatic wait_eoq();
        logic [31:0] d;
        for (int n = 0; n < 1000; n++) begin
            csr_read(2'd3, d);
            if (d[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int snap_w, snap_r, mism;
        for (int w = 0; w < 256; w++) mem[w] = 32'h0;
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R12 reset rx_ready", {31'h0, rx_ready}, 32'h0);
        chk("R1 reset mem_req", {31'h0, mem_req}, 32'h0);
        csr_read(2'd0, d); chk("R1 reset control", d, 32'h0);
        csr_read(2'd3, d); chk("R10 reset eoq", d, 32'h0);
        chk("R11 reset drop_count", 32'(drop_count), 32'h0);

        // run bit missing: no fetch, frame dropped
        set_desc(32'h0, BUF_A, 32'h0, 1'b1, 16'd64, 1'b1);
        @(negedge clk);
        csr_write(2'd0, 32'h0000_0001);
        snap_r = req_cnt;
        start_q(32'h0);
        idle(20);
        chk("R1 no request without run", 32'(req_cnt - snap_r), 32'h0);
        snap_w = wr_cnt;
        send_frame(6, 9, 1'b0, 1'b0);
        idle(2);
        chk("R11 drop counted", 32'(drop_count), 32'h1);
        chk("R11 no write on drop", 32'(wr_cnt - snap_w), 32'h0);
        csr_write(2'd0, 32'h0000_8001);
        send_frame(16, 1, 1'b0, 1'b0);
        wait_eoq();
        @(negedge clk);
        chk("R1 started by run bit", mem[4], 32'hABCD_0010);
        csr_write(2'd3, 32'h1);

        // vector table
        for (int v = 0; v < 8; v++) begin
            string tag;
            set_desc(32'h0, BUF_A, 32'h0, 1'b1, VEC[v].cap, 1'b1);
            @(negedge clk);
            start_q(32'h0);
            send_frame(int'(VEC[v].len), v + 2, VEC[v].crc, VEC[v].ovr);
            wait_eoq();
            @(negedge clk);
            if (VEC[v].stat[12] || VEC[v].stat[9]) tag = "R8";
            else if (VEC[v].stat[11]) tag = "R6";
            else if (VEC[v].stat[4]) tag = "R7";
            else tag = "R5";
            chk({"R5 length word vec ", tag}, mem[4], {16'hABCD, VEC[v].cnt});
            chk({tag, " status word"}, mem[5], {VEC[v].cap, VEC[v].stat});
            mism = 0;
            for (int i = 0; i < int'(VEC[v].cnt); i++)
                if (rd_byte(BUF_A + 32'(i)) != fb(v + 2, i)) mism++;
            chk("R2 buffer contents", 32'(mism), 32'h0);
            chk("R4 byte after data untouched",
                {24'h0, rd_byte(BUF_A + 32'(VEC[v].cnt))}, 32'h0000_00EE);
            csr_read(2'd3, d); chk("R9 eoq after last", d, 32'h1);
            csr_write(2'd3, 32'h1);
        end

        // owner bit clear: stall
        set_desc(32'h0, BUF_A, 32'h0, 1'b1, 16'd64, 1'b0);
        @(negedge clk);
        snap_w = wr_cnt;
        start_q(32'h0);
        idle(30);
        chk("R3 no write on unowned", 32'(wr_cnt - snap_w), 32'h0);
        chk("R3 descriptor untouched", mem[5], 32'h0040_0000);
        csr_read(2'd2, d); chk("R3 valid cleared", d, 32'h0);
        send_frame(10, 5, 1'b0, 1'b0);
        idle(2);
        chk("R11 drop after stall", 32'(drop_count), 32'h2);

        // two-descriptor chain
        set_desc(32'h0, BUF_A, 32'h40, 1'b0, 16'd64, 1'b1);
        set_desc(32'h40, BUF_B, 32'h0, 1'b1, 16'd64, 1'b1);
        @(negedge clk);
        start_q(32'h0);
        chk("R12 no ready before fetch", {31'h0, rx_ready}, 32'h0);
        send_frame(16, 3, 1'b0, 1'b0);
        for (int n = 0; n < 100 && mem[5][15]; n++) @(negedge clk);
        csr_read(2'd3, d); chk("R9 no eoq mid chain", d, 32'h0);
        send_frame(9, 4, 1'b0, 1'b0);
        wait_eoq();
        @(negedge clk);
        chk("R9 second length word", mem[16 + 4], 32'hABCD_0009);
        chk("R7 second status", mem[16 + 5], 32'h0040_0113);
        chk("R9 second buffer byte", {24'h0, rd_byte(BUF_B + 32'd8)}, {24'h0, fb(4, 8)});
        csr_read(2'd1, d); chk("R9 pointer followed", d, 32'h40);

        // write-1-to-clear
        csr_write(2'd3, 32'h0);
        csr_read(2'd3, d); chk("R10 write 0 keeps", d, 32'h1);
        csr_write(2'd3, 32'h1);
        csr_read(2'd3, d); chk("R10 write 1 clears", d, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule